// File: doc/BRIEF.md
# Live Coefficient RAM Update Controller

This block lets a host replace coefficients in a DSP's coefficient RAM while the DSP program keeps running. The host talks over a simple serial link: a shift clock, a data line and an active-low request. In one request the host issues a load command and streams up to sixteen 16-bit words into a local buffer. In a later request it issues a commit command with a 9-bit start address.

The block does not write the RAM at once. It watches the running program's coefficient address. It writes buffered word k into location start+k only when execution reaches that location, and only after words 0..k-1 have gone in. Each coefficient therefore changes at a known point in program flow, and no pass through the program sees a half-updated set out of order.

A ready output is low from the accepted load command until the whole update is written. It also stays low for a minimum time that is longer for shorter updates.

Top module: `coef_live_update`

## Requirements
- R1: After the synchronous active-low reset, `ready` is 1, `ram_we` is 0 and no update is pending.
- R2: A request whose first byte is 0xA8 (bits sent MSB first, sampled on rising `host_sclk`) starts a load. Each following pair of bytes forms one word, high byte first. `ready` goes to 0 once the load command is taken.
- R3: Only the first 16 words of a load are kept. Any further words are dropped and are never written to the RAM.
- R4: A request whose first byte is 0xA4, followed by a byte whose bit 0 is address bit 8 and then a byte holding address bits 7..0, commits the loaded words at that 9-bit start address.
- R5: While an update is pending, a clock with `exec_valid`=1 and `exec_addr` equal to start+k (k = next unwritten word) produces, on the following clock, `ram_we`=1, `ram_addr`=start+k and `ram_wdata`=word k.
- R6: Words are committed strictly in order. Execution of address start+k+1 before start+k has been written produces no write.
- R7: While words remain pending, `ready` is 0. It returns to 1 in the same cycle that the last word's write appears, once the minimum hold of R8 has elapsed.
- R8: After a commit of n words, `ready` stays 0 for at least (16-n)*2 clocks, even if all writes finish sooner.
- R9: A load command that arrives while an update is pending is ignored. The pending update completes with its original data.
- R10: A first byte other than 0xA8 or 0xA4 makes the rest of that request ignored. Releasing `host_req_n` mid-byte throws away the partial bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DSP clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sclk | input | 1 | Serial shift clock from host (asynchronous) |
| host_sdi | input | 1 | Serial data from host |
| host_req_n | input | 1 | Active-low transfer request |
| exec_addr | input | 9 | Coefficient address the program is using now |
| exec_valid | input | 1 | `exec_addr` is valid this clock |
| ram_we | output | 1 | Coefficient RAM write strobe |
| ram_addr | output | 9 | Coefficient RAM write address |
| ram_wdata | output | 16 | Coefficient RAM write data |
| ready | output | 1 | High when no update is loading, pending or held |

## Verification
The bench builds the block with its defaults: 16-bit words, 9-bit addresses and a 16-word buffer. With a 9-bit address, a start above 255 tests the upper-address byte. With a 16-word depth, an 18-word load tests the truncation, and a one-word commit gives the longest minimum ready hold (30 clocks). A behavioural model predicts each RAM write per clock while the program address walks forwards, backwards and past pending targets.

// File: rtl/coef_upd_pkg.sv
// Shared constants and types for the live coefficient update block.
// Assumes command bytes are fixed by the host protocol.
package coef_upd_pkg;
    localparam logic [7:0] CMD_LOAD   = 8'hA8;
    localparam logic [7:0] CMD_COMMIT = 8'hA4;

    typedef enum logic [2:0] {
        PS_IDLE,   // waiting for command byte
        PS_DATA,   // receiving data word bytes
        PS_AHI,    // receiving upper address byte
        PS_ALO,    // receiving lower address byte
        PS_DROP    // ignore until request release
    } parse_e;
endpackage

// File: rtl/coef_serial_rx.sv
// Serial byte receiver. It brings the host clock, data and request into the
// clk domain through two flops and samples data on each synchronised rising
// edge of the shift clock.
// Assumes each host_sclk phase lasts at least three clk cycles.
module coef_serial_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_sclk,
    input  logic       host_sdi,
    input  logic       host_req_n,
    output logic       active,
    output logic       byte_vld,
    output logic [7:0] byte_data
);
    logic [2:0] meta_q, sync_q;  // {req_n, sdi, sclk}
    logic       sclk_d;
    logic [2:0] bit_cnt;
    logic [6:0] shreg;
    logic       sclk_rise;

    assign active    = !sync_q[2];
    assign sclk_rise = sync_q[0] && !sclk_d;

    // Two-flop synchroniser for the host lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 3'b100;
            sync_q <= 3'b100;
            sclk_d <= 1'b0;
        end else begin
            meta_q <= {host_req_n, host_sdi, host_sclk};
            sync_q <= meta_q;
            sclk_d <= sync_q[0];
        end
    end

    // Shift register and byte framing; partial bits cleared on release
    always_ff @(posedge clk) begin
        byte_vld <= 1'b0;
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_data <= '0;
        end else if (!active) begin
            bit_cnt <= '0;
        end else if (sclk_rise) begin
            shreg   <= {shreg[5:0], sync_q[1]};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
                byte_vld  <= 1'b1;
                byte_data <= {shreg, sync_q[1]};
            end
        end
    end

    AST_BYTE_IN_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(active)); // R10
endmodule

// File: rtl/coef_cmd_parse.sv
// Command parser. It decodes the load and commit commands from received
// bytes, assembles data words into buffer writes and issues one commit
// pulse with start address and word count.
// Assumes ADDR_W <= 16.
module coef_cmd_parse
    import coef_upd_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 9,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              busy,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_idx,
    output logic [WORD_W-1:0] buf_wdata,
    output logic              arm,
    output logic [ADDR_W-1:0] arm_addr,
    output logic [CNT_W-1:0]  arm_cnt,
    output logic              loading
);
    parse_e           st;
    logic             half;
    logic [7:0]       hi_q;
    logic [CNT_W-1:0] cnt;
    logic [15:0]      addr_full;

    assign addr_full = {hi_q, byte_data};

    // Byte-level command state machine
    always_ff @(posedge clk) begin
        buf_we <= 1'b0;
        arm    <= 1'b0;
        if (!rst_n) begin
            st        <= PS_IDLE;
            half      <= 1'b0;
            hi_q      <= '0;
            cnt       <= '0;
            loading   <= 1'b0;
            buf_idx   <= '0;
            buf_wdata <= '0;
            arm_addr  <= '0;
            arm_cnt   <= '0;
        end else if (!active) begin
            st   <= PS_IDLE;
            half <= 1'b0;
        end else if (byte_vld) begin
            case (st)
                PS_IDLE: begin
                    if (byte_data == CMD_LOAD && !busy) begin
                        st      <= PS_DATA;
                        cnt     <= '0;
                        half    <= 1'b0;
                        loading <= 1'b1;
                    end else if (byte_data == CMD_COMMIT) begin
                        st <= PS_AHI;
                    end else begin
                        st <= PS_DROP;
                    end
                end
                PS_DATA: begin
                    half <= !half;
                    if (!half) begin
                        hi_q <= byte_data;
                    end else if (cnt < CNT_W'(DEPTH)) begin
                        buf_we    <= 1'b1;
                        buf_idx   <= cnt[IDX_W-1:0];
                        buf_wdata <= WORD_W'({hi_q, byte_data});
                        cnt       <= cnt + CNT_W'(1);
                    end
                end
                PS_AHI: begin
                    hi_q <= byte_data;
                    st   <= PS_ALO;
                end
                PS_ALO: begin
                    st <= PS_DROP;
                    if (!busy && loading) begin
                        arm      <= 1'b1;
                        arm_addr <= addr_full[ADDR_W-1:0];
                        arm_cnt  <= cnt;
                        loading  <= 1'b0;
                    end
                end
                default: st <= PS_DROP;
            endcase
        end
    end

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH)); // R3
    AST_NO_ARM_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> !$past(busy)); // R9
endmodule

// File: rtl/coef_commit.sv
// Commit engine. It holds the word buffer and the pending update, and
// writes the next word when the execution address reaches its target. It
// also times the minimum low period of ready.
// Assumes arm never arrives while an update is pending.
module coef_commit #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 9,
    parameter int DEPTH  = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int HOLD_W = $clog2(2 * DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_we,
    input  logic [IDX_W-1:0]  buf_idx,
    input  logic [WORD_W-1:0] buf_wdata,
    input  logic              arm,
    input  logic [ADDR_W-1:0] arm_addr,
    input  logic [CNT_W-1:0]  arm_cnt,
    input  logic              loading,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic              exec_valid,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic              pending,
    output logic              ready
);
    logic [WORD_W-1:0] wbuf [DEPTH];
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  idx, num;
    logic [HOLD_W-1:0] hold;
    logic [ADDR_W-1:0] target;
    logic              hit;

    assign target = base + ADDR_W'(idx);
    assign hit    = pending && exec_valid && (exec_addr == target);
    assign ready  = !pending && !loading && (hold == '0);

    // Word buffer storage, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) wbuf[i] <= '0;
        end else if (buf_we) begin
            wbuf[buf_idx] <= buf_wdata;
        end
    end

    // Pending update tracking and RAM write generation
    always_ff @(posedge clk) begin
        ram_we <= 1'b0;
        if (!rst_n) begin
            pending   <= 1'b0;
            base      <= '0;
            idx       <= '0;
            num       <= '0;
            hold      <= '0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            if (hold != '0) hold <= hold - HOLD_W'(1);
            if (arm) begin
                pending <= (arm_cnt != '0);
                base    <= arm_addr;
                idx     <= '0;
                num     <= arm_cnt;
                hold    <= HOLD_W'(2 * (DEPTH - int'(arm_cnt)));
            end else if (hit) begin
                ram_we    <= 1'b1;
                ram_addr  <= target;
                ram_wdata <= wbuf[idx[IDX_W-1:0]];
                idx       <= idx + CNT_W'(1);
                if (idx + CNT_W'(1) == num) pending <= 1'b0;
            end
        end
    end

    AST_WRITE_AT_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ($past(exec_valid) && ram_addr == $past(exec_addr))); // R5
    AST_STEP_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && $past(pending)) |-> (idx == $past(idx) || idx == $past(idx) + CNT_W'(1))); // R6
    AST_NO_WRITE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !$past(ready)); // R7
    AST_ARM_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> !pending); // R9
endmodule

// File: rtl/coef_live_update.sv
// Top level of the live coefficient update block. It joins the serial
// receiver, the command parser and the commit engine.
// Assumes host lines are asynchronous to clk and slower than clk/6.
module coef_live_update #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 9,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sclk,
    input  logic              host_sdi,
    input  logic              host_req_n,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic              exec_valid,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic              ready
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              active, byte_vld;
    logic [7:0]        byte_data;
    logic              buf_we, arm, loading, pending;
    logic [IDX_W-1:0]  buf_idx;
    logic [WORD_W-1:0] buf_wdata;
    logic [ADDR_W-1:0] arm_addr;
    logic [CNT_W-1:0]  arm_cnt;

    coef_serial_rx u_rx (
        .clk(clk), .rst_n(rst_n),
        .host_sclk(host_sclk), .host_sdi(host_sdi), .host_req_n(host_req_n),
        .active(active), .byte_vld(byte_vld), .byte_data(byte_data)
    );

    coef_cmd_parse #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_parse (
        .clk(clk), .rst_n(rst_n),
        .active(active), .byte_vld(byte_vld), .byte_data(byte_data),
        .busy(pending),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
        .arm(arm), .arm_addr(arm_addr), .arm_cnt(arm_cnt), .loading(loading)
    );

    coef_commit #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_commit (
        .clk(clk), .rst_n(rst_n),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
        .arm(arm), .arm_addr(arm_addr), .arm_cnt(arm_cnt), .loading(loading),
        .exec_addr(exec_addr), .exec_valid(exec_valid),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .pending(pending), .ready(ready)
    );
endmodule

// File: tb/tb_coef_live_update.sv
module tb_coef_live_update;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sclk = 1'b0, host_sdi = 1'b0, host_req_n = 1'b1;
    logic [8:0] exec_addr = '0;
    logic       exec_valid = 1'b0;
    logic       ram_we, ready;
    logic [8:0] ram_addr;
    logic [15:0] ram_wdata;

    int vectors = 0, miscompares = 0;
    bit done = 0;
    bit rdy_chk = 0;
    string cur = "R1";

    // behavioural reference state
    logic [15:0] mq[$];
    int  mstart = 0, midx = 0, mn = 0;
    bit  mpend = 0;
    bit  exp_we = 0;
    int  exp_addr = 0;
    logic [15:0] exp_data = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    coef_live_update dut (
        .clk(clk), .rst_n(rst_n),
        .host_sclk(host_sclk), .host_sdi(host_sdi), .host_req_n(host_req_n),
        .exec_addr(exec_addr), .exec_valid(exec_valid),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ready(ready)
    );

    // reference: next pending word is written when execution reaches it
    always @(posedge clk) begin
        exp_we = 0;
        if (rst_n && mpend && exec_valid && exec_addr == 9'(mstart + midx)) begin
            exp_we   = 1;
            exp_addr = (mstart + midx) % 512;
            exp_data = mq[midx];
            midx++;
            if (midx == mn) mpend = 0;
        end
    end

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (ram_we !== exp_we || (exp_we && (ram_addr !== 9'(exp_addr) || ram_wdata !== exp_data))) begin
                miscompares++;
                $display("FAIL %s write: we=%0b addr=%0h data=%h expected we=%0b addr=%0h data=%h",
                         cur, ram_we, ram_addr, ram_wdata, exp_we, exp_addr, exp_data);
            end
            if (rdy_chk && ready !== !mpend) begin
                miscompares++;
                $display("FAIL %s ready: got %0b expected %0b", cur, ready, !mpend);
            end
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic send_bits(input logic [7:0] v, input int nb);
        for (int i = nb - 1; i >= 0; i--) begin
            host_sdi = v[i];
            repeat (4) @(negedge clk);
            host_sclk = 1'b1;
            repeat (4) @(negedge clk);
            host_sclk = 1'b0;
        end
    endtask

    task automatic req_begin();
        @(negedge clk); host_req_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic req_end();
        repeat (4) @(negedge clk);
        host_req_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic load(input logic [15:0] w[$]);
        req_begin();
        send_bits(8'hA8, 8);
        foreach (w[i]) begin
            send_bits(w[i][15:8], 8);
            send_bits(w[i][7:0], 8);
        end
        req_end();
    endtask

    task automatic commit_bytes(input int a);
        send_bits(8'hA4, 8);
        send_bits(8'(a >> 8) & 8'h01, 8);
        send_bits(8'(a), 8);
    endtask

    task automatic model_arm(input int a, input logic [15:0] w[$], input int n);
        mq = w; mstart = a; midx = 0; mn = n; mpend = (n != 0);
    endtask

    task automatic drive(input int a);
        @(negedge clk); exec_addr = 9'(a); exec_valid = 1'b1;
    endtask

    task automatic idle(input int n);
        @(negedge clk); exec_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_up();
    end

    initial begin
        logic [15:0] w[$];
        int seq[$];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cur = "R1"; rdy_chk = 1;
        repeat (3) @(negedge clk);
        chk(ready === 1'b1, "R1", ready, 1);
        chk(ram_we === 1'b0, "R1", ram_we, 0);
        rdy_chk = 0;

        // R2, R5, R6, R7: five words from address 10 in program order
        cur = "R2";
        w = '{16'h1234, 16'hABCD, 16'h0F0F, 16'h8001, 16'h7FFE};
        load(w);
        chk(ready === 1'b0, "R2", ready, 0);
        req_begin(); commit_bytes(10); req_end();
        model_arm(10, w, 5);
        repeat (40) @(negedge clk);
        cur = "R5,R6,R7"; rdy_chk = 1;
        seq = '{7, 8, 9, 10, 11, 13, 16, 11, 12, 13, 14, 15};
        foreach (seq[i]) drive(seq[i]);
        idle(3);
        chk(midx == 5, "R6", midx, 5);
        rdy_chk = 0;

        // R4: start address above 255
        cur = "R4";
        w = '{16'h5555, 16'hAAAA, 16'hC3C3};
        load(w);
        req_begin(); commit_bytes(9'h1F0); req_end();
        model_arm(9'h1F0, w, 3);
        repeat (40) @(negedge clk);
        rdy_chk = 1;
        seq = '{9'h0F0, 9'h1F0, 9'h0F1, 9'h1F1, 9'h1F2};
        foreach (seq[i]) drive(seq[i]);
        idle(3);
        rdy_chk = 0;

        // R3: eighteen words loaded, sixteen kept
        cur = "R3";
        w.delete();
        for (int i = 0; i < 18; i++) w.push_back(16'(16'h1000 + i * 16'h0111));
        load(w);
        req_begin(); commit_bytes(9'h020); req_end();
        model_arm(9'h020, w, 16);
        repeat (10) @(negedge clk);
        rdy_chk = 1;
        for (int a = 9'h020; a <= 9'h031; a++) drive(a);
        idle(3);
        chk(ready === 1'b1, "R3", ready, 1);
        rdy_chk = 0;

        // R8: one-word commit keeps ready low for the minimum hold
        cur = "R8";
        w = '{16'hBEEF};
        load(w);
        req_begin(); commit_bytes(5);
        repeat (4) @(negedge clk);
        model_arm(5, w, 1);
        drive(5);
        idle(2);
        chk(ready === 1'b0, "R8", ready, 0);
        host_req_n = 1'b1;
        repeat (40) @(negedge clk);
        chk(ready === 1'b1, "R8", ready, 1);

        // R9: load while pending is ignored
        cur = "R9";
        w = '{16'h1111, 16'h2222};
        load(w);
        req_begin(); commit_bytes(50); req_end();
        model_arm(50, w, 2);
        load('{16'h3333, 16'h4444});
        chk(ready === 1'b0, "R9", ready, 0);
        repeat (40) @(negedge clk);
        rdy_chk = 1;
        drive(50); drive(51);
        idle(3);
        rdy_chk = 0;

        // R10: unknown command and aborted partial byte
        cur = "R10";
        req_begin(); send_bits(8'h55, 8); send_bits(8'hA8, 8); req_end();
        chk(ready === 1'b1, "R10", ready, 1);
        req_begin(); send_bits(8'h0A, 4); req_end();
        req_begin(); send_bits(8'h08, 4); req_end();
        chk(ready === 1'b1, "R10", ready, 1);
        rdy_chk = 1;
        drive(9'h030); drive(9'h031);
        idle(3);
        rdy_chk = 0;

        finish_up();
    end
endmodule